// File: doc/BRIEF.md
# Parallel flash command interpreter

This block models the control logic of a byte-wide parallel NOR flash with an 18-bit address and an 8-bit data bus. It samples the active-low chip-enable, output-enable and write-enable strobes on the system clock. It decodes the multi-write unlock handshake and the commands that follow it. It then runs a byte program, a sector erase or a whole-array erase against a small on-chip storage array, without any further help from the host. While an operation runs, reads return status bits. When the block is idle, reads return array contents.

Each of the five sectors is backed by `2**LOW_W` bytes. Byte offsets within a sector alias, so a sector is represented by its low address bits only. The top sector is a boot sector. A one-way lockout command protects the boot sector against program and erase until the next reset. Operation durations are parameter cycle counts, scaled down from microseconds and milliseconds.

Top module: `flash_ctl`

## Requirements
- R1: After reset every stored byte reads FFh, no operation is running, no command sequence is open and the boot lockout is clear.
- R2: `rdata_oe_o` is high exactly while both `ce_ni` and `oe_ni` are low, and `rdata_o` is 00h whenever `rdata_oe_o` is low. While idle, a read returns the stored byte at `addr_i`.
- R3: A bus write is taken on a low-to-high transition of `we_ni` seen while `ce_ni` is low, with address and data sampled in that cycle. Transitions of `we_ni` while `ce_ni` is high are ignored. Unlock matching uses address bits [14:0]: the first write is AAh to 5555h and the second is 55h to 2AAAh.
- R4: A third write of A0h to 5555h arms byte program. The next write supplies the target address and data. The block then stays busy for `PROG_CYC` cycles.
- R5: A third write of 80h to 5555h, followed by AAh to 5555h and 55h to 2AAAh, opens erase. A sixth write of 30h to any address erases the sector holding that address. A sixth write of 10h to 5555h erases the whole array. Either erase is busy for `ERASE_CYC` cycles.
- R6: While busy, a read returns bit 7 as the complement of bit 7 of the program data (0 during an erase), bit 6 as a toggle that inverts after each completed read, and bits 5..0 as 0. The toggle holds its value while idle.
- R7: Sectors are chosen by address bits [17:13]: 30–31 boot, 29 and 28 two parameter sectors, 16–27 the 96 KB main sector, 0–15 the 128 KB main sector.
- R8: A sixth write of 40h to 5555h after the erase-open sequence sets the boot lockout, which stays set until reset. After that, a program or sector erase aimed at the boot sector never goes busy and changes nothing, and a whole-array erase leaves the boot sector unchanged.
- R9: A write that does not match the expected step returns the interpreter to read-array mode, as does a write of F0h at any step (including the program-data step). The partial sequence is dropped.
- R10: Programming stores the AND of the old byte and the new data, so it can only clear bits. Erase sets every affected byte to FFh. Results become visible once busy ends.
- R11: Writes that arrive while an operation is busy are ignored and do not advance any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low; commits on its rising edge |
| addr_i | input | 18 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data or status byte |
| rdata_oe_o | output | 1 | Read data valid, drive enable for the bus |

## Verification
The bound checker watches, on every cycle, the invariants that need no array model:
- the busy window never runs past the longest operation;
- the status byte has zero low bits, and its toggle flips on each completed read while busy and holds while idle;
- reads are quiet when not enabled;
- the lockout is sticky;
- the sequencer stays idle while busy.

Array contents can only be shown by the directed scenarios, which compare read data with values computed from the requirements:
- AND-only programming;
- sector and whole-array erase extent;
- rejection of broken or aborted sequences;
- writes ignored while busy;
- boot protection after lockout.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 8;
  localparam int UNL_W  = 15;
  localparam int NSEC   = 5;
  localparam int SEC_BOOT = 4;

  localparam logic [UNL_W-1:0] A_KEY1 = 15'h5555;
  localparam logic [UNL_W-1:0] A_KEY2 = 15'h2AAA;
  localparam logic [DATA_W-1:0] D_KEY1 = 8'hAA;
  localparam logic [DATA_W-1:0] D_KEY2 = 8'h55;
  localparam logic [DATA_W-1:0] D_PROG = 8'hA0;
  localparam logic [DATA_W-1:0] D_ERS  = 8'h80;
  localparam logic [DATA_W-1:0] D_CHIP = 8'h10;
  localparam logic [DATA_W-1:0] D_SECT = 8'h30;
  localparam logic [DATA_W-1:0] D_LOCK = 8'h40;
  localparam logic [DATA_W-1:0] D_ABRT = 8'hF0;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5} seq_t;
  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_CHIP} op_t;

  function automatic logic [2:0] sec_of(input logic [ADDR_W-1:0] a);
    logic [4:0] u;
    u = a[ADDR_W-1:ADDR_W-5];
    if (u >= 5'd30)      return 3'(SEC_BOOT);
    else if (u == 5'd29) return 3'd3;
    else if (u == 5'd28) return 3'd2;
    else if (u >= 5'd16) return 3'd1;
    else                 return 3'd0;
  endfunction
endpackage

// File: rtl/flash_strobe.sv
module flash_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic wr_o,
  output logic rd_act_o,
  output logic rd_done_o
);
  logic we_q, act_q;

  assign rd_act_o  = !ce_ni && !oe_ni;
  assign wr_o      = !ce_ni && !we_q && we_ni;
  assign rd_done_o = act_q && !rd_act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= 1'b1;
      act_q <= 1'b0;
    end else begin
      we_q  <= we_ni;
      act_q <= rd_act_o;
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              busy_i,
  input  logic [UNL_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output op_t               op_o,
  output logic              lock_req_o,
  output seq_t              state_o
);
  seq_t state_q, state_d;
  logic at1, at2;

  assign at1 = (addr_i == A_KEY1);
  assign at2 = (addr_i == A_KEY2);
  assign state_o = state_q;

  always_comb begin
    state_d    = state_q;
    start_o    = 1'b0;
    op_o       = OP_PROG;
    lock_req_o = 1'b0;
    if (wr_i && !busy_i) begin
      state_d = S_IDLE;
      if (data_i != D_ABRT) begin
        unique case (state_q)
          S_IDLE: if (at1 && data_i == D_KEY1) state_d = S_U1;
          S_U1:   if (at2 && data_i == D_KEY2) state_d = S_U2;
          S_U2: begin
            if (at1 && data_i == D_PROG)     state_d = S_PGM;
            else if (at1 && data_i == D_ERS) state_d = S_E3;
          end
          S_PGM: start_o = 1'b1;
          S_E3:  if (at1 && data_i == D_KEY1) state_d = S_E4;
          S_E4:  if (at2 && data_i == D_KEY2) state_d = S_E5;
          S_E5: begin
            if (data_i == D_SECT) begin
              start_o = 1'b1;
              op_o    = OP_SECT;
            end else if (at1 && data_i == D_CHIP) begin
              start_o = 1'b1;
              op_o    = OP_CHIP;
            end else if (at1 && data_i == D_LOCK) begin
              lock_req_o = 1'b1;
            end
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/flash_core.sv
module flash_core
  import flash_pkg::*;
#(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  parameter int LOW_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_t               op_i,
  input  logic              lock_req_i,
  input  logic              rd_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              tog_o,
  output logic              lock_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH     = 2 ** LOW_W;
  localparam int MEM_N     = NSEC * DEPTH;
  localparam int IDX_W     = $clog2(MEM_N);
  localparam int MAXC      = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W     = $clog2(MAXC + 1);
  localparam int BOOT_BASE = SEC_BOOT * DEPTH;

  logic [DATA_W-1:0] mem [MEM_N];
  logic              busy_q, tog_q, lock_q;
  logic [CNT_W-1:0]  cnt_q;
  op_t               op_q;
  logic [IDX_W-1:0]  base_q, idx_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        sec_in;
  logic [IDX_W-1:0]  base_in, idx_in;
  logic              blocked;

  assign sec_in  = sec_of(addr_i);
  assign base_in = IDX_W'(sec_in) * IDX_W'(DEPTH);
  assign idx_in  = base_in + IDX_W'(addr_i[LOW_W-1:0]);
  assign blocked = lock_q && (op_i != OP_CHIP) && (sec_in == 3'(SEC_BOOT));

  assign busy_o = busy_q;
  assign tog_o  = tog_q;
  assign lock_o = lock_q;
  assign rdata_o = busy_q ? {(op_q == OP_PROG) ? ~data_q[DATA_W-1] : 1'b0, tog_q, {(DATA_W-2){1'b0}}}
                          : mem[idx_in];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MEM_N; k++) mem[IDX_W'(k)] <= '1;
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_PROG;
      base_q <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      if (lock_req_i) lock_q <= 1'b1;
      if (busy_q && rd_done_i) tog_q <= ~tog_q;
      if (!busy_q) begin
        if (start_i && !blocked) begin
          busy_q <= 1'b1;
          cnt_q  <= (op_i == OP_PROG) ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
          op_q   <= op_i;
          base_q <= base_in;
          idx_q  <= idx_in;
          data_q <= data_i;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
        unique case (op_q)
          OP_PROG: mem[idx_q] <= mem[idx_q] & data_q;
          OP_SECT: for (int j = 0; j < DEPTH; j++) mem[base_q + IDX_W'(j)] <= '1;
          OP_CHIP: for (int k = 0; k < MEM_N; k++)
                     if (!(lock_q && k >= BOOT_BASE)) mem[IDX_W'(k)] <= '1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
  import flash_pkg::*;
#(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  parameter int LOW_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic wr_w, rd_act_w, rd_done_w, start_w, lock_req_w, busy_w, tog_w, lock_w;
  op_t  op_w;
  seq_t state_w;
  logic [DATA_W-1:0] core_rd_w;

  flash_strobe u_strobe (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .wr_o(wr_w), .rd_act_o(rd_act_w), .rd_done_o(rd_done_w)
  );

  flash_seq u_seq (
    .clk_i, .rst_ni, .wr_i(wr_w), .busy_i(busy_w),
    .addr_i(addr_i[UNL_W-1:0]), .data_i(wdata_i),
    .start_o(start_w), .op_o(op_w), .lock_req_o(lock_req_w), .state_o(state_w)
  );

  flash_core #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .LOW_W(LOW_W)) u_core (
    .clk_i, .rst_ni, .start_i(start_w), .op_i(op_w), .lock_req_i(lock_req_w),
    .rd_done_i(rd_done_w), .addr_i, .data_i(wdata_i),
    .busy_o(busy_w), .tog_o(tog_w), .lock_o(lock_w), .rdata_o(core_rd_w)
  );

  assign rdata_oe_o = rd_act_w;
  assign rdata_o    = rd_act_w ? core_rd_w : '0;
endmodule

// File: rtl/flash_ctl_chk.sv
module flash_ctl_chk
  import flash_pkg::*;
#(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic              busy_i,
  input logic              tog_i,
  input logic              lock_i,
  input seq_t              state_i
);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 2);

  logic [CNT_W-1:0] run_q;
  logic act_q, rd_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      act_q <= 1'b0;
    end else begin
      run_q <= busy_i ? run_q + 1'b1 : '0;
      act_q <= !ce_ni && !oe_ni;
    end
  end

  assign rd_end = act_q && !(!ce_ni && !oe_ni);

  p_busy_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> run_q < CNT_W'(MAXC));
  p_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> (rdata_o == '0 && !rdata_oe_o));
  p_status_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rdata_oe_o) |-> rdata_o[DATA_W-3:0] == '0);
  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_end) |=> tog_i != $past(tog_i));
  p_toggle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(tog_i));
  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i);
  p_seq_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> state_i == S_IDLE);
endmodule

bind flash_ctl flash_ctl_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_chk (
  .clk_i, .rst_ni, .ce_ni, .oe_ni, .rdata_o, .rdata_oe_o,
  .busy_i(busy_w), .tog_i(tog_w), .lock_i(lock_w), .state_i(state_w)
);

// File: tb/sim_flash_ctl.sv
`timescale 1ns/1ps
module sim_flash_ctl;
  localparam int PROG_CYC  = 16;
  localparam int ERASE_CYC = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_ctl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .LOW_W(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_wr_noce(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [17:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    bus_wr(18'h05555, 8'hAA);
    bus_wr(18'h02AAA, 8'h55);
  endtask

  task automatic pgm(input logic [17:0] a, input logic [7:0] d);
    unlock(); bus_wr(18'h05555, 8'hA0); bus_wr(a, d);
  endtask

  task automatic erase_open();
    unlock(); bus_wr(18'h05555, 8'h80); unlock();
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk); #1;
    check("R2 idle drive enable", {7'd0, rdata_oe}, 8'h00);
    check("R2 idle bus quiet", rdata, 8'h00);
    bus_rd(18'h3FFFF, v); check("R1 boot erased at reset", v, 8'hFF);
    bus_rd(18'h00005, v); check("R1 main erased at reset", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] s1, s2, v;
    pgm(18'h00005, 8'h3C);
    bus_rd(18'h00005, s1);
    bus_rd(18'h00005, s2);
    check("R6 busy dq7 complement", {7'd0, s1[7]}, 8'h01);
    check("R6 busy low bits", {2'b0, s1[5:0]}, 8'h00);
    check("R6 dq6 toggles", {7'd0, s1[6] ^ s2[6]}, 8'h01);
    settle(PROG_CYC + 4);
    bus_rd(18'h00005, v); check("R4 programmed byte", v, 8'h3C);
    bus_rd(18'h00005, s1); bus_rd(18'h00005, s2);
    check("R6 no toggle when idle", s1 ^ s2, 8'h00);
    pgm(18'h00005, 8'hC3); settle(PROG_CYC + 4);
    bus_rd(18'h00005, v); check("R10 program only clears", v, 8'h00);
  endtask

  task automatic t_broken();
    logic [7:0] v;
    bus_wr(18'h05555, 8'hAA); bus_wr(18'h01234, 8'h55);
    bus_wr(18'h05555, 8'hA0); bus_wr(18'h00100, 8'h12);
    settle(PROG_CYC + 4);
    bus_rd(18'h00100, v); check("R9 broken unlock ignored", v, 8'hFF);
    unlock(); bus_wr(18'h05555, 8'hF0); bus_wr(18'h05555, 8'hA0); bus_wr(18'h00003, 8'h00);
    settle(PROG_CYC + 4);
    bus_rd(18'h00003, v); check("R9 F0 aborts sequence", v, 8'hFF);
    bus_wr_noce(18'h05555, 8'hAA); bus_wr_noce(18'h02AAA, 8'h55);
    bus_wr_noce(18'h05555, 8'hA0); bus_wr_noce(18'h00002, 8'h00);
    settle(PROG_CYC + 4);
    bus_rd(18'h00002, v); check("R3 write with ce high ignored", v, 8'hFF);
  endtask

  task automatic t_sector();
    logic [7:0] v;
    pgm(18'h3A001, 8'h5A); settle(PROG_CYC + 4);
    pgm(18'h38002, 8'h11); settle(PROG_CYC + 4);
    pgm(18'h20003, 8'h22); settle(PROG_CYC + 4);
    erase_open(); bus_wr(18'h3A000, 8'h30);
    bus_rd(18'h3A001, v);
    check("R6 erase status dq7 zero", {v[7], 1'b0, v[5:0]}, 8'h00);
    settle(ERASE_CYC + 4);
    bus_rd(18'h3A001, v); check("R5 sector erased", v, 8'hFF);
    bus_rd(18'h38002, v); check("R7 neighbour parameter sector kept", v, 8'h11);
    bus_rd(18'h37FFB, v); check("R7 96K main sector kept", v, 8'h22);
  endtask

  task automatic t_chip();
    logic [7:0] v;
    erase_open(); bus_wr(18'h05555, 8'h10); settle(ERASE_CYC + 4);
    bus_rd(18'h00005, v); check("R5 chip erase main", v, 8'hFF);
    bus_rd(18'h38002, v); check("R10 chip erase parameter", v, 8'hFF);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    pgm(18'h20001, 8'h77);
    pgm(18'h20002, 8'h00);
    settle(PROG_CYC + 4);
    bus_rd(18'h20001, v); check("R4 first program done", v, 8'h77);
    bus_rd(18'h20002, v); check("R11 write while busy ignored", v, 8'hFF);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    pgm(18'h3C004, 8'h0F); settle(PROG_CYC + 4);
    erase_open(); bus_wr(18'h05555, 8'h40);
    pgm(18'h3C004, 8'h00);
    bus_rd(18'h3C004, v); check("R8 locked program not busy", v, 8'h0F);
    erase_open(); bus_wr(18'h3E000, 8'h30);
    bus_rd(18'h3C004, v); check("R8 locked sector erase ignored", v, 8'h0F);
    pgm(18'h00006, 8'h66); settle(PROG_CYC + 4);
    erase_open(); bus_wr(18'h05555, 8'h10); settle(ERASE_CYC + 4);
    bus_rd(18'h3C004, v); check("R8 chip erase spares boot", v, 8'h0F);
    bus_rd(18'h00006, v); check("R8 chip erase clears main", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_broken();
    t_sector();
    t_chip();
    t_busy_ignore();
    t_lock();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule